// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block keeps the status flags of an asynchronous serial port. Single-cycle event strobes arrive from the transmit and receive datapaths: a byte moved from the transmit buffer into the shifter, the shifter finishing, and a received frame completing, with or without a framing or parity error. The transmit and receive enables, two DMA service strobes and a CPU read/write port also act on the flags. The flags are presented as one registered 8-bit status byte, and two interrupt requests are driven from them.

The CPU clears a sticky flag in two steps. A read must first show the flag as 1. A later write with a 0 in that bit position then clears it. The one write that follows a read uses up the permission the read granted. A DMA access made in answer to an interrupt request clears the matching buffer flag directly. Whenever a hardware set and a clear land in the same cycle, the set takes effect.

Top module: `serial_status_flags`

## Requirements
- R1: In reset, `status` equals 0x84 (bit 7 transmit-buffer-empty = 1, bit 2 transmit-end = 1, all others 0), and both interrupt outputs are 0.
- R2: Bit 7 (transmit-buffer-empty) is set one cycle after any cycle with `tx_en` = 0, and one cycle after a `tx_load` strobe while `tx_en` = 1. `tx_irq` equals bit 7 AND `tx_irq_en`.
- R3: When `rx_done` arrives while `rx_en` = 1, with neither error input set and bit 6 (receive-buffer-full) at 0, the next cycle has bit 6 = 1 and bit 1 equal to `rx_mp_in`. `rx_irq` equals bit 6 AND `rx_irq_en`.
- R4: When an error-free `rx_done` arrives while bit 6 is already 1, bit 5 (overrun) becomes 1, bit 6 stays 1 and bit 1 keeps its value.
- R5: An `rx_done` with `rx_frm_err` sets bit 4 and one with `rx_par_err` sets bit 3. Neither case sets bit 6 or changes bit 1.
- R6: While `rx_en` = 0, receive strobes change no bit, and bit 6 keeps its value.
- R7: A CPU write with a 0 in bit 7, 6, 5, 4 or 3 clears that flag only if a CPU read was made after the previous write while the flag read as 1. Writing a 1 leaves the flag unchanged. Any write removes the permission for every flag.
- R8: `dma_tx_ack` clears bit 7 and `dma_rx_ack` clears bit 6, each only while its own interrupt output is 1. Otherwise they have no effect.
- R9: When a hardware set of a flag and a CPU or DMA clear of it fall in the same cycle, the flag ends at 1.
- R10: CPU writes never change bits 2 and 1. Bit 0 takes `cpu_wdata[0]` on every write.
- R11: Bit 2 (transmit-end) is 1 after any cycle with `tx_en` = 0. It is cleared by `tx_load`. It is set by `tx_shift_done` when bit 7 is 1, and left unchanged by `tx_shift_done` when bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_irq_en | input | 1 | Enables the transmit-ready interrupt |
| rx_irq_en | input | 1 | Enables the receive-ready interrupt |
| tx_load | input | 1 | Strobe: transmit buffer moved into the shifter |
| tx_shift_done | input | 1 | Strobe: the transmit shifter finished a frame |
| rx_done | input | 1 | Strobe: a receive frame completed |
| rx_frm_err | input | 1 | Qualifies `rx_done`: framing error |
| rx_par_err | input | 1 | Qualifies `rx_done`: parity error |
| rx_mp_in | input | 1 | Multiprocessor bit of the completed frame |
| dma_tx_ack | input | 1 | Strobe: DMA wrote the transmit buffer |
| dma_rx_ack | input | 1 | Strobe: DMA read the receive buffer |
| cpu_rd | input | 1 | CPU read strobe of the status byte |
| cpu_wr | input | 1 | CPU write strobe of the status byte |
| cpu_wdata | input | 8 | CPU write data |
| status | output | 8 | Status byte |
| tx_irq | output | 1 | Transmit-ready interrupt request |
| rx_irq | output | 1 | Receive-ready interrupt request |

## Verification
Every flag bit is registered, so a lost or wrong event shows on `status` and the interrupt outputs one cycle after the strobe that caused it. A fault in the per-flag read permission stays hidden until the next CPU write: a clear that should not happen, or a clear that fails to happen. For that reason each clearable bit is swept over the cases read/no read and written 0/1. A stale permission shows up as a flag that vanishes on a second write with no read in between.

// File: rtl/ssf_pkg.sv
package ssf_pkg;
   localparam int STAT_W  = 8;
   // bit positions of the status byte (software decodes these)
   localparam int B_TXE   = 7;
   localparam int B_RXF   = 6;
   localparam int B_OVR   = 5;
   localparam int B_FRM   = 4;
   localparam int B_PAR   = 3;
   localparam int B_TEND  = 2;
   localparam int B_MPR   = 1;
   localparam int B_MPT   = 0;
   // sticky, software-clearable flags occupy the top N_CLR bits
   localparam int CLR_LO  = B_PAR;
   localparam int N_CLR   = STAT_W - CLR_LO;
   // index of each sticky flag inside the clearable vector
   localparam int K_TXE   = B_TXE - CLR_LO;
   localparam int K_RXF   = B_RXF - CLR_LO;
   localparam int K_OVR   = B_OVR - CLR_LO;
   localparam int K_FRM   = B_FRM - CLR_LO;
   localparam int K_PAR   = B_PAR - CLR_LO;

   typedef logic [N_CLR-1:0] clr_vec_t;
endpackage

// File: rtl/ssf_flag_cell.sv
module ssf_flag_cell #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic hw_clr,
   input  logic cpu_rd,
   input  logic cpu_wr,
   input  logic cpu_wbit,
   output logic flag
);
   logic armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag  <= RST_VAL;
         armed <= 1'b0;
      end else begin
         if (hw_set)
            flag <= 1'b1;
         else if (hw_clr)
            flag <= 1'b0;
         else if (cpu_wr && armed && !cpu_wbit)
            flag <= 1'b0;
         armed <= (cpu_rd & flag) | (armed & ~cpu_wr);
      end
   end

   // R9: a set always lands
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> flag);
   // R7: without a prior read showing 1, only DMA can clear
   p_no_blind_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !armed && !hw_clr) |=> flag);
   // R7: a write without a read leaves no permission behind
   p_arm_used_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && !cpu_rd) |=> !armed);
endmodule

// File: rtl/ssf_rx_path.sv
module ssf_rx_path (
   input  logic rx_en,
   input  logic rx_done,
   input  logic rx_frm_err,
   input  logic rx_par_err,
   input  logic rxf_now,
   output logic set_rxf,
   output logic set_ovr,
   output logic set_frm,
   output logic set_par,
   output logic cap_mp
);
   logic done_q, bad;

   always_comb begin
      done_q  = rx_en & rx_done;
      bad     = rx_frm_err | rx_par_err;
      set_frm = done_q & rx_frm_err;
      set_par = done_q & rx_par_err;
      set_rxf = done_q & ~bad & ~rxf_now;
      set_ovr = done_q & ~bad & rxf_now;
      cap_mp  = set_rxf;
   end
endmodule

// File: rtl/ssf_tx_path.sv
module ssf_tx_path (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic tx_load,
   input  logic tx_shift_done,
   input  logic txe_now,
   output logic set_txe,
   output logic tend
);
   always_comb set_txe = ~tx_en | tx_load;

   always_ff @(posedge clk) begin
      if (!rst_n)
         tend <= 1'b1;
      else if (!tx_en)
         tend <= 1'b1;
      else if (tx_load)
         tend <= 1'b0;
      else if (tx_shift_done && txe_now)
         tend <= 1'b1;
   end

   // R11: disabled transmitter reports end of transmission
   p_tend_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> tend);
   // R11: a load always starts a new transmission
   p_tend_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && tx_load) |=> !tend);
endmodule

// File: rtl/serial_status_flags.sv
module serial_status_flags #(
   parameter int DMA_GATED = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_en,
   input  logic       rx_en,
   input  logic       tx_irq_en,
   input  logic       rx_irq_en,
   input  logic       tx_load,
   input  logic       tx_shift_done,
   input  logic       rx_done,
   input  logic       rx_frm_err,
   input  logic       rx_par_err,
   input  logic       rx_mp_in,
   input  logic       dma_tx_ack,
   input  logic       dma_rx_ack,
   input  logic       cpu_rd,
   input  logic       cpu_wr,
   input  logic [7:0] cpu_wdata,
   output logic [7:0] status,
   output logic       tx_irq,
   output logic       rx_irq
);
   import ssf_pkg::*;

   if (DMA_GATED < 0 || DMA_GATED > 1) begin : g_bad_param
      $error("DMA_GATED must be 0 or 1");
   end

   clr_vec_t flags, hw_set, hw_clr;
   logic set_txe_tx, tend;
   logic set_rxf, set_ovr, set_frm, set_par, cap_mp;
   logic dma_tx_clr, dma_rx_clr;
   logic mpr, mpt;

   ssf_tx_path i_tx (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_load(tx_load),
      .tx_shift_done(tx_shift_done), .txe_now(flags[K_TXE]),
      .set_txe(set_txe_tx), .tend(tend)
   );

   ssf_rx_path i_rx (
      .rx_en(rx_en), .rx_done(rx_done), .rx_frm_err(rx_frm_err),
      .rx_par_err(rx_par_err), .rxf_now(flags[K_RXF]),
      .set_rxf(set_rxf), .set_ovr(set_ovr), .set_frm(set_frm),
      .set_par(set_par), .cap_mp(cap_mp)
   );

   if (DMA_GATED == 1) begin : g_dma_gated
      always_comb begin
         dma_tx_clr = dma_tx_ack & tx_irq;
         dma_rx_clr = dma_rx_ack & rx_irq;
      end
   end else begin : g_dma_open
      always_comb begin
         dma_tx_clr = dma_tx_ack;
         dma_rx_clr = dma_rx_ack;
      end
   end

   always_comb begin
      hw_set        = '0;
      hw_clr        = '0;
      hw_set[K_TXE] = set_txe_tx;
      hw_set[K_RXF] = set_rxf;
      hw_set[K_OVR] = set_ovr;
      hw_set[K_FRM] = set_frm;
      hw_set[K_PAR] = set_par;
      hw_clr[K_TXE] = dma_tx_clr;
      hw_clr[K_RXF] = dma_rx_clr;
   end

   for (genvar k = 0; k < N_CLR; k++) begin : g_flag
      ssf_flag_cell #(.RST_VAL(k == K_TXE)) i_cell (
         .clk(clk), .rst_n(rst_n),
         .hw_set(hw_set[k]), .hw_clr(hw_clr[k]),
         .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
         .cpu_wbit(cpu_wdata[k + CLR_LO]),
         .flag(flags[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mpr <= 1'b0;
         mpt <= 1'b0;
      end else begin
         if (cap_mp) mpr <= rx_mp_in;
         if (cpu_wr) mpt <= cpu_wdata[B_MPT];
      end
   end

   always_comb begin
      status = {flags, tend, mpr, mpt};
      tx_irq = flags[K_TXE] & tx_irq_en;
      rx_irq = flags[K_RXF] & rx_irq_en;
   end

   // R4: a completed frame finding a full buffer is reported as overrun
   p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && rx_done && !rx_frm_err && !rx_par_err && status[B_RXF])
      |=> (status[B_OVR] && status[B_RXF]));
   // R2: a disabled transmitter always shows an empty buffer
   p_txe_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> status[B_TXE]);
   // R6: a disabled receiver keeps the buffer-full flag
   p_rxf_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !dma_rx_ack && !cpu_wr) |=> $stable(status[B_RXF]));
   // R10: read-only bits ignore the CPU
   p_ro_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && (|cpu_wdata[B_TEND:B_MPR]) && !rx_done && tx_en
       && !tx_load && !tx_shift_done) |=> $stable(status[B_TEND:B_MPR]));
endmodule

// File: tb/test_serial_status_flags.sv
module test_serial_status_flags;
   localparam time CLK_P = 10ns;

   logic clk = 1'b0;
   logic rst_n, tx_en, rx_en, tx_irq_en, rx_irq_en;
   logic tx_load, tx_shift_done, rx_done, rx_frm_err, rx_par_err, rx_mp_in;
   logic dma_tx_ack, dma_rx_ack, cpu_rd, cpu_wr;
   logic [7:0] cpu_wdata, status;
   logic tx_irq, rx_irq;
   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   serial_status_flags i_serial_status_flags (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
      .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en), .tx_load(tx_load),
      .tx_shift_done(tx_shift_done), .rx_done(rx_done),
      .rx_frm_err(rx_frm_err), .rx_par_err(rx_par_err), .rx_mp_in(rx_mp_in),
      .dma_tx_ack(dma_tx_ack), .dma_rx_ack(dma_rx_ack), .cpu_rd(cpu_rd),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .status(status),
      .tx_irq(tx_irq), .rx_irq(rx_irq)
   );

   task automatic tick(); @(negedge clk); endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic rd_stat(); cpu_rd = 1; tick(); cpu_rd = 0; endtask
   task automatic wr_stat(input logic [7:0] d);
      cpu_wr = 1; cpu_wdata = d; tick(); cpu_wr = 0; cpu_wdata = 0;
   endtask
   task automatic frame(input logic mp, input logic fe, input logic pe);
      rx_done = 1; rx_mp_in = mp; rx_frm_err = fe; rx_par_err = pe; tick();
      rx_done = 0; rx_mp_in = 0; rx_frm_err = 0; rx_par_err = 0;
   endtask
   task automatic load(); tx_load = 1; tick(); tx_load = 0; endtask
   task automatic sdone(); tx_shift_done = 1; tick(); tx_shift_done = 0; endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 0; tx_en = 0; rx_en = 0; tx_irq_en = 0; rx_irq_en = 0;
      tx_load = 0; tx_shift_done = 0; rx_done = 0; rx_frm_err = 0;
      rx_par_err = 0; rx_mp_in = 0; dma_tx_ack = 0; dma_rx_ack = 0;
      cpu_rd = 0; cpu_wr = 0; cpu_wdata = 0;
      repeat (3) tick();
      chk("R1 reset byte", status, 8'h84);
      chk("R1 irqs", {6'b0, tx_irq, rx_irq}, 8'h00);
      rst_n = 1; tick();
      chk("R1 after release", status, 8'h84);
      tx_en = 1; rx_en = 1; tick();
      chk("R11 enabled idle", status, 8'h84);

      // R7: write without read does nothing
      wr_stat(8'h00);
      chk("R7 blind write", status, 8'h84);
      rd_stat(); wr_stat(8'h00);
      chk("R7 read then clear", status, 8'h04);
      load();
      chk("R2 load sets txe, R11 clears tend", status, 8'h80);
      rd_stat(); wr_stat(8'hFF);
      chk("R7 write one keeps, R10 bit0", status, 8'h81);
      wr_stat(8'h00);
      chk("R7 permission consumed", status, 8'h80);
      sdone();
      chk("R11 shift done with txe", status, 8'h84);
      load(); rd_stat(); wr_stat(8'h00);
      chk("R7 clear txe", status, 8'h00);
      sdone();
      chk("R11 shift done without txe", status, 8'h00);
      wr_stat(8'h06);
      chk("R10 ro bits", status, 8'h00);

      // R2 / R8 transmit interrupt and DMA
      tx_irq_en = 1; tick();
      chk("R2 irq low", {7'b0, tx_irq}, 8'h00);
      load();
      chk("R2 irq high", {7'b0, tx_irq}, 8'h01);
      dma_tx_ack = 1; tick(); dma_tx_ack = 0;
      chk("R8 dma tx clears", {status[7:1], tx_irq}, 8'h00);
      tx_irq_en = 0; load();
      dma_tx_ack = 1; tick(); dma_tx_ack = 0;
      chk("R8 dma tx ignored without irq", status, 8'h80);

      // receive
      rx_irq_en = 1;
      frame(1, 0, 0);
      chk("R3 frame stored", status, 8'hC2);
      chk("R3 rx irq", {7'b0, rx_irq}, 8'h01);
      frame(0, 0, 0);
      chk("R4 overrun", status, 8'hE2);
      rx_en = 0; frame(0, 1, 1); frame(0, 0, 0);
      chk("R6 rx disabled", status, 8'hE2);
      rx_en = 1;
      dma_rx_ack = 1; tick(); dma_rx_ack = 0;
      chk("R8 dma rx clears", status, 8'hA2);
      chk("R8 rx irq low", {7'b0, rx_irq}, 8'h00);
      frame(0, 1, 0);
      chk("R5 framing", status, 8'hB2);
      frame(0, 0, 1);
      chk("R5 parity", status, 8'hBA);

      // R9: set beats clear in same cycle
      rd_stat();
      cpu_wr = 1; cpu_wdata = 8'h00; tx_load = 1; rx_done = 1; rx_frm_err = 1;
      tick();
      cpu_wr = 0; tx_load = 0; rx_done = 0; rx_frm_err = 0;
      chk("R9 set wins", status, 8'h92);

      // R7 sweep: each sticky flag x read/no read x write 0/1
      rx_irq_en = 0;
      for (int b = 3; b < 8; b++) begin
         for (int arm = 0; arm < 2; arm++) begin
            for (int wb = 0; wb < 2; wb++) begin
               rd_stat(); wr_stat(8'h00);
               case (b)
                  7: load();
                  6: frame(0, 0, 0);
                  5: begin frame(0, 0, 0); frame(0, 0, 0); end
                  4: frame(0, 1, 0);
                  default: frame(0, 0, 1);
               endcase
               if (arm == 1) rd_stat();
               wr_stat(wb == 1 ? 8'hFF : ~(8'h01 << b));
               chk($sformatf("R7 sweep bit%0d arm%0d w%0d", b, arm, wb),
                   {7'b0, status[b]}, (arm == 1 && wb == 0) ? 8'h00 : 8'h01);
            end
         end
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule